// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a register-mapped general purpose I/O controller for up to 32 pins, reached through an APB-style slave port. Each implemented pin has its own 8-bit configuration word. That word gates the output data onto the pin and enables the pad driver, so the pin can be driven high, driven low or left floating. It also lets the synchronized pad level into the input register and picks one of five interrupt-detect conditions.

Software can write the output data register as a whole. It can also update single bits atomically through a set-bits register and a clear-bits register. Configuration can be written per pin, for eight adjacent pins in one write, or for all pins in one write. Each pin raises a sticky pending flag that software clears by writing ones. The pending flags are exported as a per-pin interrupt vector. The pad side exports output data, an output enable and an input for each pin.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, all configuration words, the output data register and the pending flags are zero, so `pad_oe`, `pad_out`, `irq_vec` and `prdata` are zero.
- R2: Word index k (byte address 4k, k = 0..31) holds the configuration of pin k in bits 7:0. The fields are: bit0 output-data enable, bit1 input enable, bit2 driver enable, bit3 interrupt enable, bits 7:5 trigger type. Bits 31:8 read as zero.
- R3: Writing byte address 0x88 loads the output register, with bit i going to pin i, and a read returns it. `pad_out[i]` = output bit i AND config bit0, and `pad_oe[i]` = config bit2. A pin with bit2 clear floats, whatever its output bit holds.
- R4: At 0xA4, a written 1 sets that output bit. At 0xA0, a written 1 clears that output bit. Written 0s leave bits unchanged in both registers.
- R5: A write to 0x8C copies bits 7:0 into the configuration of every implemented pin. A write to 0x90 + 4n copies them into pins 8n to 8n+7 only.
- R6: `pad_in` passes through two flops before use. A read of 0x84 returns the synchronized level AND config bit1, and the level stays readable while the driver is off.
- R7: Trigger types are 0 for level high, 1 for level low, 2 for rising edge, 3 for falling edge and 4 for either edge. An edge is the synchronized level compared with its value one cycle earlier.
- R8: A pin whose config bit3 is clear never sets its pending flag.
- R9: Pending flags (read at 0x80, mirrored on `irq_vec`) stay set until a 1 is written to that bit at 0x80. The clear takes priority in its own cycle. A level condition that persists sets the flag again on the next cycle.
- R10: Configuration, output and pending bits for pins at or above `NUM_PORTS` read as zero and ignore writes.
- R11: Writes take effect on the access-phase edge (`psel` and `penable` high). Read data is captured on the setup-phase edge and held on `prdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pad_in | input | NUM_PORTS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PORTS | Pad output data |
| pad_oe | output | NUM_PORTS | Pad driver enable |
| irq_vec | output | NUM_PORTS | Per-pin pending interrupt flags |

## Verification
The properties assume that bus transfers are well formed. Each access-phase cycle follows a setup cycle at the same address, and `pwdata` is stable while `penable` is high. The pending-flag properties also assume that only a write to the pending register can lower a flag. The stimulus drives every transfer as a three-cycle setup/access/idle sequence on the falling clock edge. It changes `pad_in` only between transfers, so synchronizer latency never overlaps a register write that the checks depend on.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int CFG_W     = 8;
  localparam int CB_OUT_EN = 0;
  localparam int CB_IN_EN  = 1;
  localparam int CB_DRV_EN = 2;
  localparam int CB_IRQ_EN = 3;
  localparam int CB_TRIG   = 5;

  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // word indices (byte address >> 2)
  localparam logic [5:0] WI_PEND  = 6'd32;
  localparam logic [5:0] WI_IN    = 6'd33;
  localparam logic [5:0] WI_OUT   = 6'd34;
  localparam logic [5:0] WI_ALL   = 6'd35;
  localparam logic [5:0] WI_GRP0  = 6'd36;
  localparam logic [5:0] WI_GRP3  = 6'd39;
  localparam logic [5:0] WI_CLR   = 6'd40;
  localparam logic [5:0] WI_SET   = 6'd41;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             level,
  input  logic             clr,
  output logic             pending
);
  logic  prev_q;
  logic  pend_q;
  logic  hit;
  trig_e trig;

  assign trig = trig_e'(cfg[CB_TRIG +: 3]);

  always_comb begin
    unique case (trig)
      TRIG_HIGH: hit = level;
      TRIG_LOW:  hit = ~level;
      TRIG_RISE: hit = level & ~prev_q;
      TRIG_FALL: hit = ~level & prev_q;
      TRIG_BOTH: hit = level ^ prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (clr)
        pend_q <= 1'b0;
      else if (cfg[CB_IRQ_EN] && hit)
        pend_q <= 1'b1;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [7:0]           paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic [NUM_PORTS-1:0] pad_in,
  output logic [NUM_PORTS-1:0] pad_out,
  output logic [NUM_PORTS-1:0] pad_oe,
  output logic [NUM_PORTS-1:0] irq_vec
);
  localparam int GRP_W = 8;

  logic [5:0]           widx;
  logic                 wr_en;
  logic                 rd_en;
  logic [CFG_W-1:0]     cfg_q [NUM_PORTS];
  logic [NUM_PORTS-1:0] out_q;
  logic [NUM_PORTS-1:0] lvl_sync;
  logic [NUM_PORTS-1:0] in_vis;
  logic [NUM_PORTS-1:0] clr_vec;
  logic [NUM_PORTS-1:0] pend_vec;
  logic [NUM_PORTS-1:0] out_en_vec;
  logic [31:0]          rd_word;
  logic [31:0]          prdata_q;

  assign widx  = paddr[7:2];
  assign wr_en = psel & penable & pwrite;
  assign rd_en = psel & ~penable & ~pwrite;

  gpio_in_sync #(.WIDTH(NUM_PORTS)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (lvl_sync)
  );

  // configuration words: per pin, per group of eight, or broadcast
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PORTS; i++) cfg_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (widx == 6'(i))
          cfg_q[i] <= pwdata[CFG_W-1:0];
        else if (widx == WI_ALL)
          cfg_q[i] <= pwdata[CFG_W-1:0];
        else if (widx >= WI_GRP0 && widx <= WI_GRP3 && widx[1:0] == 2'(i / GRP_W))
          cfg_q[i] <= pwdata[CFG_W-1:0];
      end
    end
  end

  // output data with atomic set / clear
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (wr_en) begin
      unique case (widx)
        WI_OUT:  out_q <= pwdata[NUM_PORTS-1:0];
        WI_SET:  out_q <= out_q | pwdata[NUM_PORTS-1:0];
        WI_CLR:  out_q <= out_q & ~pwdata[NUM_PORTS-1:0];
        default: out_q <= out_q;
      endcase
    end
  end

  assign clr_vec = (wr_en && widx == WI_PEND) ? pwdata[NUM_PORTS-1:0] : '0;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    gpio_port_irq irq_i (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cfg_q[g]),
      .level   (lvl_sync[g]),
      .clr     (clr_vec[g]),
      .pending (pend_vec[g])
    );
    assign in_vis[g]     = lvl_sync[g] & cfg_q[g][CB_IN_EN];
    assign out_en_vec[g] = cfg_q[g][CB_OUT_EN];
    assign pad_oe[g]     = cfg_q[g][CB_DRV_EN];
  end

  assign pad_out = out_q & out_en_vec;
  assign irq_vec = pend_vec;

  always_comb begin
    rd_word = '0;
    if (widx < 6'd32) begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (widx == 6'(i)) rd_word = 32'(cfg_q[i]);
    end else begin
      unique case (widx)
        WI_PEND: rd_word = 32'(pend_vec);
        WI_IN:   rd_word = 32'(in_vis);
        WI_OUT:  rd_word = 32'(out_q);
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        prdata_q <= '0;
    else if (rd_en) prdata_q <= rd_word;
  end

  assign prdata = prdata_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NUM_PORTS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [7:0]           paddr,
  input logic [31:0]          pwdata,
  input logic [NUM_PORTS-1:0] out_q,
  input logic [NUM_PORTS-1:0] pad_oe,
  input logic [NUM_PORTS-1:0] irq_vec
);
  logic wr_pend, wr_set, wr_clr, wr_outs;
  logic [NUM_PORTS-1:0] wd;
  logic was_rst;

  assign wd      = pwdata[NUM_PORTS-1:0];
  assign wr_pend = psel & penable & pwrite & (paddr[7:2] == 6'd32);
  assign wr_set  = psel & penable & pwrite & (paddr[7:2] == 6'd41);
  assign wr_clr  = psel & penable & pwrite & (paddr[7:2] == 6'd40);
  assign wr_outs = wr_set | wr_clr | (psel & penable & pwrite & (paddr[7:2] == 6'd34));

  always_ff @(posedge clk) was_rst <= rst;

  // R1: first cycle out of reset has drivers off and nothing pending
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (pad_oe == '0 && irq_vec == '0));

  // R9: a pending flag only drops after a clear write
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst || was_rst)
    (($past(irq_vec) & ~irq_vec) != '0) |-> $past(wr_pend));

  // R9: clear wins over a new event in its own cycle
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> ((irq_vec & $past(wd)) == '0));

  // R4: set-bits forces written ones high
  p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((out_q & $past(wd)) == $past(wd)));

  // R4: clear-bits forces written ones low
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((out_q & $past(wd)) == '0));

  // R11: output data only moves on an access-phase write
  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst || was_rst)
    !$past(wr_outs) |-> $stable(out_q));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .out_q   (out_q),
  .pad_oe  (pad_oe),
  .irq_vec (irq_vec)
);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;
  localparam int NP = 20;
  localparam logic [31:0] MASK = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, irq_vec;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_vec(irq_vec)
  );

  // {is_write, addr, wdata, expected read}
  localparam logic [72:0] VEC [18] = '{
    {1'b1, 8'h00, 32'h0000_0005, 32'h0},          // R2 pin0 output only
    {1'b0, 8'h00, 32'h0,         32'h0000_0005},  // R2
    {1'b1, 8'h88, 32'hFFFF_FFFF, 32'h0},          // R3
    {1'b0, 8'h88, 32'h0,         32'h000F_FFFF},  // R3 R10 upper bits zero
    {1'b1, 8'hA0, 32'h0000_000F, 32'h0},          // R4 clear
    {1'b0, 8'h88, 32'h0,         32'h000F_FFF0},  // R4
    {1'b1, 8'hA4, 32'h0000_0003, 32'h0},          // R4 set
    {1'b0, 8'h88, 32'h0,         32'h000F_FFF3},  // R4
    {1'b1, 8'h8C, 32'h0000_0003, 32'h0},          // R5 all
    {1'b0, 8'h4C, 32'h0,         32'h0000_0003},  // R5 pin19
    {1'b0, 8'h50, 32'h0,         32'h0},          // R10 pin20
    {1'b1, 8'h94, 32'hFFFF_FF07, 32'h0},          // R5 group1
    {1'b0, 8'h20, 32'h0,         32'h0000_0007},  // R5 pin8, R2 upper zero
    {1'b0, 8'h3C, 32'h0,         32'h0000_0007},  // R5 pin15
    {1'b0, 8'h40, 32'h0,         32'h0000_0003},  // R5 pin16 untouched
    {1'b0, 8'h1C, 32'h0,         32'h0000_0003},  // R5 pin7 untouched
    {1'b1, 8'h50, 32'h0000_00FF, 32'h0},          // R10 write ignored
    {1'b0, 8'h50, 32'h0,         32'h0}           // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 irq_vec", 32'(irq_vec), 32'h0);
    check("R1 prdata", prdata, 32'h0);
    bus_read(8'h88, rd); check("R1 out reg", rd, 32'h0);
    bus_read(8'h04, rd); check("R1 cfg1", rd, 32'h0);

    for (int k = 0; k < 18; k++) begin
      if (VEC[k][72]) bus_write(VEC[k][71:64], VEC[k][63:32]);
      else begin
        bus_read(VEC[k][71:64], rd);
        check($sformatf("R11 vector %0d", k), rd, VEC[k][31:0]);
      end
    end

    // R3 driver enable only for group1 (cfg 0x07), data gated by bit0
    check("R3 pad_oe", 32'(pad_oe), 32'h0000_FF00);
    check("R3 pad_out", 32'(pad_out), 32'h000F_FFF3);

    // R6 input readable with driver off
    pad_in = 20'hA5A5D; idle(4);
    bus_read(8'h84, rd); check("R6 input", rd, 32'h000A_5A5D);
    bus_write(8'h00, 32'h5);
    bus_read(8'h84, rd); check("R6 input disabled pin0", rd, 32'h000A_5A5C);

    // R7 R8 R9 interrupt modes
    pad_in = '0;
    bus_write(8'h8C, 32'h2);
    bus_write(8'h00, 32'h0A);  // level high
    bus_write(8'h04, 32'h2A);  // level low
    bus_write(8'h08, 32'h4A);  // rise
    bus_write(8'h0C, 32'h6A);  // fall
    bus_write(8'h10, 32'h8A);  // both
    bus_write(8'h14, 32'h42);  // rise, irq disabled
    check("R3 pad_out gated pin0", 32'(pad_out[0]), 32'h0);
    idle(4);
    bus_write(8'h80, MASK); idle(4);
    bus_read(8'h80, rd); check("R9 level low persists", rd, 32'h2);
    check("R9 irq_vec", 32'(irq_vec), 32'h2);
    pad_in = 20'h3D; idle(5);
    bus_read(8'h80, rd); check("R7 rise/high/both R8 disabled", rd, 32'h17);
    bus_write(8'h80, MASK); idle(4);
    bus_read(8'h80, rd); check("R9 edges cleared levels reset", rd, 32'h03);
    pad_in = 20'h20; idle(5);
    bus_read(8'h80, rd); check("R7 fall/both R9 sticky", rd, 32'h1B);
    bus_write(8'h80, MASK); idle(4);
    bus_read(8'h80, rd); check("R9 after clear", rd, 32'h02);
    bus_write(8'h80, 32'h2);
    check("R9 clear same cycle", 32'(irq_vec), 32'h0);
    idle(3);
    check("R9 re-set", 32'(irq_vec), 32'h2);
    bus_read(8'h88, rd); check("R3 out reg kept", rd, 32'h000F_FFF3);
    finish_run();
  end
endmodule